// File: doc/BRIEF.md
# Three-Edge Converter Control Sequencer

This block is the digital control core of a successive-approximation converter. A host drives it with two lines: an active-low chip-select strobe and a read/convert select. Successive falling edges of chip select walk the block through a fixed sequence. The first edge wakes the reference and opens the track phase. The second edge closes the track/hold switch and launches the conversion. The third edge drives the finished result onto a 16-bit tri-state data bus.

The select line means something different at each edge. At the first edge it must be low, or the edge is discarded. At the second edge it picks the power mode that follows the conversion. Low keeps the reference and its buffer running (standby). High turns them off (shutdown). At the third edge it must be high for the result to be read out.

The conversion is self-timed. A divider derives a slow bit clock from the block clock, and the search tests one bit per bit-clock period, most significant bit first. The block drives the trial code toward the capacitive DAC and reads back a single comparator bit. When the last bit has been decided, the end-of-conversion flag drops. It rises again after chip select is released at the end of readout.

Top module: `cvt_seq`

## Requirements
- R1: After either reset, eoc_no is 1, data_oe_o is 0, data_o is 0, ref_en_o is 0 and track_o is 0.
- R2: In idle, a chip-select falling edge with rdc_i low sets ref_en_o and track_o to 1. The same edge with rdc_i high is ignored, and ref_en_o and track_o stay 0.
- R3: A chip-select falling edge during acquisition clears track_o and starts conversion. eoc_no stays 1 until the conversion is complete.
- R4: rdc_i sampled at the conversion-start edge selects the power mode. 0 (standby) leaves ref_en_o at 1 after eoc_no falls. 1 (shutdown) drops ref_en_o to 0 when eoc_no falls.
- R5: The result is unsigned binary. Bit 15 is tried first, with a first trial code of 0x8000. A trial bit is kept when cmp_i is 1 (input at or above the trial code). With an ideal comparator, the result equals the sampled input code.
- R6: eoc_no falls no sooner than 16*CLK_DIV cycles and no later than 16*CLK_DIV+4 cycles after track_o falls. With the defaults (64 cycles at 250 MHz) this is far below the 4.7 us bound.
- R7: In the done state, a chip-select falling edge with rdc_i high sets data_oe_o and presents the result on data_o. The following chip-select rise clears data_oe_o and returns eoc_no to 1.
- R8: data_oe_o is 0, and data_o is 0, during acquisition and conversion.
- R9: Chip-select falling edges during conversion are ignored. They change neither the power mode nor the result, and they cause no readout.
- R10: srst_i high returns the block to idle from any state. The next chip-select falling edge with rdc_i low then begins acquisition.
- R11: In the done state, a chip-select falling edge with rdc_i low is ignored. data_oe_o stays 0 and eoc_no stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset to idle, active high |
| cs_ni | input | 1 | Chip-select strobe, active low, asynchronous |
| rdc_i | input | 1 | Read/convert select, asynchronous |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| dac_o | output | 16 | Trial or final code toward the capacitive DAC |
| track_o | output | 1 | 1 = track, 0 = hold |
| ref_en_o | output | 1 | Reference and buffer power enable |
| eoc_no | output | 1 | End of conversion, active low |
| data_o | output | 16 | Result bus value, 0 while not enabled |
| data_oe_o | output | 1 | Bus output enable (1 = driven, 0 = high impedance) |

## Verification
Some properties are checked by assertions on every cycle:
- the bus is enabled only while end-of-conversion is low, and it holds steady while enabled;
- hold is in force whenever a result is pending;
- tracking implies reference power;
- the reset state is correct;
- the conversion length stays inside its window, measured by a counter.

Other behaviours can only be shown by the bench's scenarios, which use a comparator model tied to an input code:
- which edges are discarded;
- the power mode chosen at the second edge;
- the immunity of the result to stray edges during conversion;
- the bit-exact results at the code extremes and at mid patterns.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_DONE,
    ST_READ
  } seq_state_e;
endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
  parameter int                 WIDTH   = 2,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cvt_tick.sv
module cvt_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/cvt_sar.sv
module cvt_sar #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] code_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q, mask_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      code_q <= '0;
      mask_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        code_q <= MSB;
        mask_q <= MSB;
        busy_q <= 1'b1;
      end else if (busy_q && tick_i) begin
        // keep the trial bit on cmp=1, then try the next lower bit
        code_q <= (cmp_i ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
        mask_q <= mask_q >> 1;
        if (mask_q[0]) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign code_o = code_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/cvt_fsm.sv
module cvt_fsm
  import cvt_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic cs_n_s_i,
  input  logic rdc_s_i,
  input  logic sar_done_i,
  output logic start_o,
  output logic track_o,
  output logic ref_en_o,
  output logic eoc_no,
  output logic oe_o
);
  seq_state_e state_q;
  logic cs_n_d_q, shut_q;
  logic cs_fall, cs_rise;

  assign cs_fall = cs_n_d_q && !cs_n_s_i;
  assign cs_rise = !cs_n_d_q && cs_n_s_i;
  assign start_o = (state_q == ST_ACQ) && cs_fall && !srst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_n_d_q <= 1'b1;
    else         cs_n_d_q <= cs_n_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      track_o  <= 1'b0;
      ref_en_o <= 1'b0;
      eoc_no   <= 1'b1;
      oe_o     <= 1'b0;
      shut_q   <= 1'b0;
    end else if (srst_i) begin
      state_q  <= ST_IDLE;
      track_o  <= 1'b0;
      ref_en_o <= 1'b0;
      eoc_no   <= 1'b1;
      oe_o     <= 1'b0;
      shut_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cs_fall && !rdc_s_i) begin
          state_q  <= ST_ACQ;
          track_o  <= 1'b1;
          ref_en_o <= 1'b1;
        end
        ST_ACQ: if (cs_fall) begin
          state_q <= ST_CONV;
          track_o <= 1'b0;
          shut_q  <= rdc_s_i;
        end
        ST_CONV: if (sar_done_i) begin
          state_q  <= ST_DONE;
          eoc_no   <= 1'b0;
          ref_en_o <= !shut_q;
        end
        ST_DONE: if (cs_fall && rdc_s_i) begin
          state_q <= ST_READ;
          oe_o    <= 1'b1;
        end
        ST_READ: if (cs_rise) begin
          state_q <= ST_IDLE;
          oe_o    <= 1'b0;
          eoc_no  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cvt_seq.sv
module cvt_seq #(
  parameter int WIDTH       = 16,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             cs_ni,
  input  logic             rdc_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] dac_o,
  output logic             track_o,
  output logic             ref_en_o,
  output logic             eoc_no,
  output logic [WIDTH-1:0] data_o,
  output logic             data_oe_o
);
  logic [1:0]       pins_s;
  logic             start, tick, busy, done;
  logic [WIDTH-1:0] code;

  cvt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({rdc_i, cs_ni}),
    .sync_o (pins_s)
  );

  cvt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst_i),
    .cs_n_s_i  (pins_s[0]),
    .rdc_s_i   (pins_s[1]),
    .sar_done_i(done),
    .start_o   (start),
    .track_o   (track_o),
    .ref_en_o  (ref_en_o),
    .eoc_no    (eoc_no),
    .oe_o      (data_oe_o)
  );

  cvt_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start || srst_i),
    .en_i  (busy),
    .tick_o(tick)
  );

  cvt_sar #(.WIDTH(WIDTH)) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (srst_i),
    .start_i(start),
    .tick_i (tick),
    .cmp_i  (cmp_i),
    .code_o (code),
    .busy_o (busy),
    .done_o (done)
  );

  assign dac_o  = code;
  assign data_o = data_oe_o ? code : '0;
endmodule

// File: rtl/cvt_seq_chk.sv
module cvt_seq_chk #(
  parameter int WIDTH   = 16,
  parameter int CLK_DIV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_i,
  input logic             track_o,
  input logic             ref_en_o,
  input logic             eoc_no,
  input logic [WIDTH-1:0] data_o,
  input logic             data_oe_o
);
  localparam int MIN_CYC = 16 * CLK_DIV;
  localparam int MAX_CYC = 16 * CLK_DIV + 4;

  logic        track_d_q, conv_q;
  logic [31:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      track_d_q <= 1'b0;
      conv_q    <= 1'b0;
      cnt_q     <= '0;
    end else begin
      track_d_q <= track_o;
      if (srst_i) begin
        conv_q <= 1'b0;
        cnt_q  <= '0;
      end else if (track_d_q && !track_o) begin
        conv_q <= 1'b1;
        cnt_q  <= 32'd1;
      end else if (conv_q && !eoc_no) begin
        conv_q <= 1'b0;
      end else if (conv_q) begin
        cnt_q <= cnt_q + 1;
      end
    end
  end

  a_r8_bus_only_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !eoc_no);
  a_r7_bus_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
  a_r3_hold_when_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no |-> !track_o);
  a_r2_track_needs_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    track_o |-> ref_en_o);
  a_r1_sync_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (eoc_no && !data_oe_o && !ref_en_o && !track_o));
  a_r6_conv_not_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_q |-> (cnt_q <= 32'(MAX_CYC)));
  a_r6_conv_not_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_q && !eoc_no) |-> (cnt_q >= 32'(MIN_CYC)));
endmodule

bind cvt_seq cvt_seq_chk #(.WIDTH(WIDTH), .CLK_DIV(CLK_DIV)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .srst_i   (srst_i),
  .track_o  (track_o),
  .ref_en_o (ref_en_o),
  .eoc_no   (eoc_no),
  .data_o   (data_o),
  .data_oe_o(data_oe_o)
);

// File: tb/cvt_seq_bench.sv
module cvt_seq_bench;
  localparam int W   = 16;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0, srst = 1'b0, cs_n = 1'b1, rdc = 1'b0;
  logic [W-1:0] vin = '0;
  logic [W-1:0] dac, dout;
  logic track, ref_en, eoc_n, oe, cmp;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [W-1:0] exp_q[$];
  logic oe_d = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (vin >= dac);

  cvt_seq #(.WIDTH(W), .CLK_DIV(DIV)) u_cvt_seq (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .cs_ni(cs_n), .rdc_i(rdc),
    .cmp_i(cmp), .dac_o(dac), .track_o(track), .ref_en_o(ref_en),
    .eoc_no(eoc_n), .data_o(dout), .data_oe_o(oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected result on each bus enable
  always @(negedge clk) begin
    oe_d <= oe;
    if (oe && !oe_d) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected readout", int'(dout), 0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(dout == e, "R5/R7 result", int'(dout), int'(e));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_fall(input logic r);
    @(posedge clk); #1 rdc = r; cs_n = 1'b0;
    wait_clk(5);
  endtask

  task automatic cs_rise();
    @(posedge clk); #1 cs_n = 1'b1;
    wait_clk(5);
  endtask

  task automatic start_conv(input logic [W-1:0] v, input logic shut);
    vin = v;
    cs_fall(1'b0);
    check(track && ref_en && oe == 1'b0, "R2 acquire/R8", {track, ref_en, oe}, 3'b110);
    cs_rise();
    cs_fall(shut);
    check(!track && eoc_n && !oe && dout == '0, "R3/R8 conv start", {track, eoc_n, oe}, 3'b010);
  endtask

  task automatic wait_eoc(output int n);
    n = 0;
    while (eoc_n && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic read_out(input logic [W-1:0] v);
    exp_q.push_back(v);
    cs_fall(1'b1);
    check(oe == 1'b1, "R7 bus enabled", oe, 1);
    cs_rise();
    check(!oe && eoc_n && dout == '0, "R7 release", {oe, eoc_n}, 2'b01);
  endtask

  task automatic full_conv(input logic [W-1:0] v, input logic shut);
    int n;
    start_conv(v, shut);
    cs_rise();
    wait_eoc(n);
    check(!eoc_n, "R3 eoc falls", eoc_n, 0);
    check(ref_en == !shut, "R4 power mode", ref_en, !shut);
    read_out(v);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    wait_clk(3);
    #1 rst_n = 1'b1;
    wait_clk(3);
    check(eoc_n && !oe && !ref_en && !track && dout == '0, "R1 reset",
          {eoc_n, oe, ref_en, track}, 4'b1000);

    // R2: edge with select high in idle is discarded
    cs_fall(1'b1);
    check(!track && !ref_en, "R2 ignored edge", {track, ref_en}, 0);
    cs_rise();

    // R5/R4 vectors in both modes
    full_conv(16'hA5C3, 1'b0);
    full_conv(16'h0000, 1'b1);
    full_conv(16'hFFFF, 1'b0);
    full_conv(16'h8000, 1'b1);
    full_conv(16'h7FFF, 1'b0);
    full_conv(16'h0001, 1'b1);

    // R6: conversion length measured from start edge
    start_conv(16'h3C5A, 1'b0);
    cs_rise();
    wait_eoc(n);
    n = n + 10;  // fall wait(5) + rise wait(5) already elapsed
    check(n >= 16*DIV && n <= 16*DIV + 8, "R6 conv time", n, 16*DIV);
    read_out(16'h3C5A);

    // R9: stray edges during conversion with select high
    start_conv(16'h1234, 1'b0);
    cs_rise();
    cs_fall(1'b1);
    check(!oe && eoc_n, "R9 no early read", {oe, eoc_n}, 2'b01);
    cs_rise();
    wait_eoc(n);
    check(ref_en == 1'b1, "R9 mode kept", ref_en, 1);
    // R11: select-low edge while done is discarded
    cs_fall(1'b0);
    check(!oe && !eoc_n && !track, "R11 ignored in done", {oe, eoc_n, track}, 0);
    cs_rise();
    read_out(16'h1234);

    // R10: sync reset during acquisition, then a clean cycle
    vin = 16'h4321;
    cs_fall(1'b0);
    @(posedge clk); #1 srst = 1'b1;
    @(posedge clk); #1 srst = 1'b0;
    wait_clk(1);
    check(!track && !ref_en && eoc_n && !oe, "R10 sync reset", {track, ref_en}, 0);
    cs_rise();
    full_conv(16'h4321, 1'b1);

    // R10: sync reset while result pending
    start_conv(16'h0F0F, 1'b0);
    cs_rise();
    wait_eoc(n);
    @(posedge clk); #1 srst = 1'b1;
    @(posedge clk); #1 srst = 1'b0;
    wait_clk(1);
    check(eoc_n && !ref_en && !oe, "R10 reset from done", {eoc_n, ref_en, oe}, 3'b100);

    wait_clk(4);
    check(exp_q.size() == 0, "R7 all results read", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule